// File: doc/BRIEF.md
# Transmit FIFO and Stuffing Monitor

This block watches the fill level of a transmit elastic buffer. The buffer takes one byte for each routed PCM timeslot and gives up one byte for each mapped payload byte of an outgoing framed link. The block does not hold the data. It tracks the occupancy, the byte balance over each link frame and the frame phase between the PCM side and the link side.

At every link frame marker the block decides whether that frame carries zero or four stuff bits. The decision comes from an accumulated phase lead of PCM frames over link frames. If the phase moves outside a programmable window, the block flags a stuffing error and restarts its phase accumulator.

The block has four error conditions: overflow, underrun, unequal byte counts, and stuffing error. Each one sets a sticky flag in an 8-bit status word. A read strobe on the status word clears the flags. The flags are ORed into a combined error line and into an interrupt request, and both an enable and a mask gate the interrupt. A FIFO reset strobe, issued when the PCM frame is realigned, returns the occupancy to half full and clears the per-frame measurements.

Top module: `txfifo_stuff_mon`

## Requirements
- R1: Occupancy starts at DEPTH/2 (8 by default). A write strobe while the occupancy equals DEPTH sets the overflow flag, status bit 1, and that write is not counted.
- R2: A read strobe while the occupancy is 0 sets the underrun flag, status bit 2, and that read is not counted. A write and a read in the same cycle leave the occupancy unchanged when neither hits a limit.
- R3: Each link marker sets status bit 0, the stuff decision, to 1 (four stuff bits) when the phase sum S is at least 4 and within the window. The accumulator then becomes S-4. Otherwise bit 0 is 0 and the accumulator becomes S.
- R4: Each link marker compares the write strobes and the read strobes counted since the previous marker, the marker cycle included. If the counts differ, the slip flag, status bit 3, is set. Both counts then restart from 0.
- R5: At a link marker, S = accumulator + (number of PCM markers since the previous link marker, including one in the marker cycle) - NOM_PCM (4 by default).
- R6: If S > thresh or S < -thresh at a link marker, the stuffing-error flag, status bit 4, is set. The accumulator is reset to 0 and status bit 0 becomes 0.
- R7: Flags in bits 4:1 stay set until a cycle with the status read strobe high. They read as 0 after that cycle, unless an event of the same kind occurred in the read cycle.
- R8: tx_err is the OR of status bits 4:1. irq equals tx_err AND err_rpt_en AND irq_mask.
- R9: Status bits 7:5 always read 0.
- R10: A FIFO reset strobe sets the occupancy to DEPTH/2 and clears the byte counts, the PCM marker count and the accumulator. In that cycle it raises no event and takes no stuff decision. The sticky flags and bit 0 are kept.
- R11: After the synchronous reset the status word is 0, tx_err is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One byte written (routed timeslot) |
| rd_stb | input | 1 | One byte read (mapped payload byte) |
| pcm_fm | input | 1 | PCM frame marker pulse |
| lnk_fm | input | 1 | Link frame marker pulse |
| thresh | input | 8 | Phase window half-width |
| fifo_rst | input | 1 | FIFO realignment reset strobe |
| stat_rd | input | 1 | Status read strobe (clears sticky flags) |
| err_rpt_en | input | 1 | Error report enable |
| irq_mask | input | 1 | Interrupt mask bit (1 = allowed) |
| status | output | 8 | Status word |
| tx_err | output | 1 | Combined transmit error |
| irq | output | 1 | Transmit error interrupt |

## Verification
The sharpest collision is a status read in the same cycle as a new error event, because clear and set then act on the same flag together. The bench forces this directly: it issues a read exactly when a write hits a full FIFO. Random traffic also raises read strobes often enough to land on slip and stuffing events at link markers. A second collision is a link marker that coincides with a byte strobe and a PCM marker, so the boundary cycle must be counted in both the slip and the phase sums. The bench's model counts that cycle in both sums, and every status field is compared to the model after every cycle.

// File: rtl/txm_pkg.sv
package txm_pkg;
    // status bit positions
    localparam int ST_STUFF = 0;
    localparam int ST_OVF   = 1;
    localparam int ST_UNR   = 2;
    localparam int ST_SLIP  = 3;
    localparam int ST_SERR  = 4;

    localparam int STUFF_QUANTUM = 4;

    typedef struct packed {
        logic serr;
        logic slip;
        logic unr;
        logic ovf;
    } err_evt_t;

    function automatic logic [7:0] pack_status(input err_evt_t fl, input logic stuff);
        logic [7:0] s;
        s = '0;
        s[ST_STUFF] = stuff;
        s[ST_OVF]   = fl.ovf;
        s[ST_UNR]   = fl.unr;
        s[ST_SLIP]  = fl.slip;
        s[ST_SERR]  = fl.serr;
        return s;
    endfunction
endpackage

// File: rtl/txm_occupancy.sv
module txm_occupancy #(
    parameter int DEPTH = 16,
    localparam int FW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic rd_stb,
    input  logic fifo_rst,
    output logic ovf_evt,
    output logic unr_evt
);
    localparam logic [FW-1:0] HALF = FW'(DEPTH / 2);
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    logic [FW-1:0] fill;
    logic wr_ok, rd_ok, at_full, at_empty;

    always_comb begin
        at_full  = (fill == FULL);
        at_empty = (fill == '0);
        wr_ok    = wr_stb && !at_full;
        rd_ok    = rd_stb && !at_empty;
        ovf_evt  = !fifo_rst && wr_stb && at_full;
        unr_evt  = !fifo_rst && rd_stb && at_empty;
    end

    always_ff @(posedge clk) begin
        if (rst || fifo_rst) begin
            fill <= HALF;
        end else begin
            fill <= fill + FW'(wr_ok) - FW'(rd_ok);
        end
    end

    // R10: realignment puts occupancy at half
    p_realign_half_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_rst |=> fill == HALF);
    // R2: after an underrun at most the concurrent write landed
    p_unr_floor_r2: assert property (@(posedge clk) disable iff (rst)
        unr_evt |=> fill <= FW'(1));
endmodule

// File: rtl/txm_balance.sv
module txm_balance #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic rd_stb,
    input  logic lnk_fm,
    input  logic fifo_rst,
    output logic slip_evt
);
    logic [CNT_W-1:0] wcnt, rcnt, wtot, rtot;

    always_comb begin
        wtot     = wcnt + CNT_W'(wr_stb);
        rtot     = rcnt + CNT_W'(rd_stb);
        slip_evt = !fifo_rst && lnk_fm && (wtot != rtot);
    end

    always_ff @(posedge clk) begin
        if (rst || fifo_rst || lnk_fm) begin
            wcnt <= '0;
            rcnt <= '0;
        end else begin
            wcnt <= wtot;
            rcnt <= rtot;
        end
    end

    // R4: counts restart after every link marker
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        lnk_fm |=> (wcnt == '0 && rcnt == '0));
endmodule

// File: rtl/txm_stuff.sv
module txm_stuff #(
    parameter int CNT_W   = 12,
    parameter int TH_W    = 8,
    parameter int NOM_PCM = 4,
    localparam int SW = CNT_W + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pcm_fm,
    input  logic            lnk_fm,
    input  logic [TH_W-1:0] thresh,
    input  logic            fifo_rst,
    output logic            serr_evt,
    output logic            stuff_bit
);
    import txm_pkg::*;

    logic signed [CNT_W-1:0] acc;
    logic        [CNT_W-1:0] pcnt, ptot;
    logic signed [SW-1:0]    sum, th_s, acc_nx;
    logic                    do_stuff;

    always_comb begin
        ptot     = pcnt + CNT_W'(pcm_fm);
        sum      = SW'(acc) + $signed({2'b00, ptot}) - SW'(NOM_PCM);
        th_s     = $signed({{(SW-TH_W){1'b0}}, thresh});
        serr_evt = !fifo_rst && lnk_fm && ((sum > th_s) || (sum < -th_s));
        do_stuff = !serr_evt && (sum >= SW'(STUFF_QUANTUM));
        if (serr_evt)      acc_nx = '0;
        else if (do_stuff) acc_nx = sum - SW'(STUFF_QUANTUM);
        else               acc_nx = sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            pcnt      <= '0;
            stuff_bit <= 1'b0;
        end else if (fifo_rst) begin
            acc  <= '0;
            pcnt <= '0;
        end else if (lnk_fm) begin
            acc       <= acc_nx[CNT_W-1:0];
            pcnt      <= '0;
            stuff_bit <= do_stuff;
        end else begin
            pcnt <= ptot;
        end
    end

    // R6: generator restarts on a stuffing error
    p_serr_restart_r6: assert property (@(posedge clk) disable iff (rst)
        serr_evt |=> (acc == '0 && !stuff_bit));
    // R3: stuff decision only moves at a link marker
    p_stuff_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !lnk_fm |=> $stable(stuff_bit));
endmodule

// File: rtl/txm_status.sv
module txm_status (
    input  logic              clk,
    input  logic              rst,
    input  txm_pkg::err_evt_t evt,
    input  logic              stat_rd,
    output txm_pkg::err_evt_t flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (stat_rd ? '0 : flags) | evt;
    end

    // R7: flags persist when not read
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((flags & $past(flags)) == $past(flags)));
    // R7: read without new event clears
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && evt == '0) |=> flags == '0);
endmodule

// File: rtl/txfifo_stuff_mon.sv
module txfifo_stuff_mon #(
    parameter int DEPTH   = 16,
    parameter int CNT_W   = 12,
    parameter int TH_W    = 8,
    parameter int NOM_PCM = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_stb,
    input  logic            rd_stb,
    input  logic            pcm_fm,
    input  logic            lnk_fm,
    input  logic [TH_W-1:0] thresh,
    input  logic            fifo_rst,
    input  logic            stat_rd,
    input  logic            err_rpt_en,
    input  logic            irq_mask,
    output logic [7:0]      status,
    output logic            tx_err,
    output logic            irq
);
    import txm_pkg::*;

    err_evt_t evt, flags;
    logic     stuff_bit;

    txm_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .fifo_rst(fifo_rst), .ovf_evt(evt.ovf), .unr_evt(evt.unr)
    );

    txm_balance #(.CNT_W(CNT_W)) u_bal (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .lnk_fm(lnk_fm), .fifo_rst(fifo_rst), .slip_evt(evt.slip)
    );

    txm_stuff #(.CNT_W(CNT_W), .TH_W(TH_W), .NOM_PCM(NOM_PCM)) u_stf (
        .clk(clk), .rst(rst), .pcm_fm(pcm_fm), .lnk_fm(lnk_fm),
        .thresh(thresh), .fifo_rst(fifo_rst),
        .serr_evt(evt.serr), .stuff_bit(stuff_bit)
    );

    txm_status u_st (
        .clk(clk), .rst(rst), .evt(evt), .stat_rd(stat_rd), .flags(flags)
    );

    always_comb begin
        status = pack_status(flags, stuff_bit);
        tx_err = |flags;
        irq    = tx_err && err_rpt_en && irq_mask;
    end

    // R8: interrupt only when both gates are open
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (err_rpt_en && irq_mask && status[4:1] != 4'b0));
endmodule

// File: tb/txfifo_stuff_mon_tb.sv
module txfifo_stuff_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int NOM = 4;

    logic clk = 1'b0;
    logic rst, wr_stb, rd_stb, pcm_fm, lnk_fm, fifo_rst, stat_rd, err_rpt_en, irq_mask;
    logic [7:0] thresh;
    logic [7:0] status;
    logic tx_err, irq;

    int n_chk = 0, n_bad = 0;
    // model state
    int m_fill, m_wc, m_rc, m_pc, m_acc, m_stuff;
    logic [4:1] m_fl;

    always #(CLK_PERIOD/2) clk = ~clk;

    txfifo_stuff_mon u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .pcm_fm(pcm_fm), .lnk_fm(lnk_fm), .thresh(thresh),
        .fifo_rst(fifo_rst), .stat_rd(stat_rd), .err_rpt_en(err_rpt_en),
        .irq_mask(irq_mask), .status(status), .tx_err(tx_err), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_txerr();
        return |m_fl;
    endfunction

    task automatic compare_all();
        chk("R3 stuff bit", int'(status[0]), m_stuff);
        chk("R1 overflow flag", int'(status[1]), int'(m_fl[1]));
        chk("R2 underrun flag", int'(status[2]), int'(m_fl[2]));
        chk("R4 slip flag", int'(status[3]), int'(m_fl[3]));
        chk("R6 stuff error flag", int'(status[4]), int'(m_fl[4]));
        chk("R9 upper bits", int'(status[7:5]), 0);
        chk("R8 tx_err", int'(tx_err), int'(exp_txerr()));
        chk("R8 irq", int'(irq), int'(exp_txerr() && err_rpt_en && irq_mask));
    endtask

    task automatic model_reset();
        m_fill = DEPTH/2; m_wc = 0; m_rc = 0; m_pc = 0; m_acc = 0; m_stuff = 0;
        m_fl = '0;
    endtask

    // R5/R3/R6/R4/R1/R2/R10 model step for the inputs currently driven
    task automatic model_step();
        logic [4:1] ev;
        int sum, th;
        ev = '0;
        th = int'(thresh);
        if (fifo_rst) begin
            m_fill = DEPTH/2; m_wc = 0; m_rc = 0; m_pc = 0; m_acc = 0;
        end else begin
            if (wr_stb && m_fill == DEPTH) ev[1] = 1'b1;
            if (rd_stb && m_fill == 0)     ev[2] = 1'b1;
            m_fill = m_fill + ((wr_stb && m_fill != DEPTH) ? 1 : 0)
                            - ((rd_stb && m_fill != 0) ? 1 : 0);
            m_wc += int'(wr_stb); m_rc += int'(rd_stb); m_pc += int'(pcm_fm);
            if (lnk_fm) begin
                if (m_wc != m_rc) ev[3] = 1'b1;
                sum = m_acc + m_pc - NOM;
                if (sum > th || sum < -th) begin
                    ev[4] = 1'b1; m_acc = 0; m_stuff = 0;
                end else if (sum >= 4) begin
                    m_stuff = 1; m_acc = sum - 4;
                end else begin
                    m_stuff = 0; m_acc = sum;
                end
                m_wc = 0; m_rc = 0; m_pc = 0;
            end
        end
        m_fl = (stat_rd ? 4'b0 : m_fl) | ev;
    endtask

    // one cycle: compare at negedge, drive, model, clock
    task automatic cyc(input logic w, input logic r, input logic p, input logic l,
                       input logic fr, input logic sr);
        @(negedge clk);
        compare_all();
        wr_stb = w; rd_stb = r; pcm_fm = p; lnk_fm = l; fifo_rst = fr; stat_rd = sr;
        model_step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; wr_stb = 0; rd_stb = 0; pcm_fm = 0; lnk_fm = 0;
        fifo_rst = 0; stat_rd = 0; err_rpt_en = 1; irq_mask = 1; thresh = 8'd10;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        @(negedge clk);
        chk("R11 status after reset", int'(status), 0);
        chk("R11 irq after reset", int'(irq), 0);

        // R1: eight writes fill, ninth overflows; R7 read in same cycle as event
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 1);
        idle(2);
        chk("R7 flag kept on same-cycle read", int'(status[1]), 1);
        irq_mask = 0;
        idle(1);
        chk("R8 irq masked", int'(irq), 0);
        irq_mask = 1;
        cyc(0, 0, 0, 0, 0, 1);
        idle(1);
        chk("R7 cleared after read", int'(status[1]), 0);

        // R10: realign, then R2: underrun after draining 8
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 9; i++) cyc(0, 1, 0, 0, 0, 0);
        idle(1);
        chk("R2 underrun after drain", int'(status[2]), 1);
        cyc(0, 0, 0, 0, 1, 1);
        idle(1);

        // R5/R3: six PCM markers per frame, NOM 4 -> sum 2 then 4 -> stuff
        thresh = 8'd10;
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, 0);
            cyc(1, 1, 1, 1, 0, 0);  // marker cycle counts
            idle(1);
        end
        chk("R3 stuff after lead of 4", int'(status[0]), 1);

        // R6: thresh 3, eight markers -> sum 4 > 3
        thresh = 8'd3;
        for (int i = 0; i < 7; i++) cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0);
        idle(1);
        chk("R6 stuff error flagged", int'(status[4]), 1);
        chk("R6 stuff bit cleared", int'(status[0]), 0);

        // R4: unequal bytes in a frame
        cyc(1, 0, 0, 0, 0, 1);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(0, 1, 1, 1, 0, 0);
        idle(1);
        chk("R4 slip flagged", int'(status[3]), 1);
        cyc(0, 0, 0, 0, 1, 1);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            if (k % 500 == 0) thresh = 8'($urandom_range(3, 12));
            if (k % 50 == 0) begin
                err_rpt_en = 1'($urandom_range(0, 1));
                irq_mask   = 1'($urandom_range(0, 1));
            end
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 9) == 0), (k % 40 == 39),
                ($urandom_range(0, 299) == 0), ($urandom_range(0, 7) == 0));
        end
        idle(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule